// File: doc/BRIEF.md
# Interrupt Cause and Vector Mapper

This block collects interrupt causes from two transmit queues, two receive queues and one group of miscellaneous events. Each cause is held in a cause register until it is cleared. A cause bit that is set and also enabled in the mask register is routed to one of five message vectors. A per-cause allocation table chooses the vector. Each vector raises a request towards a downstream message generator and holds it until that generator acknowledges.

Software uses a single-cycle register port to set causes on purpose, set or clear mask bits, read the mask, and program the allocation table and two per-cause policy registers. The auto-clear policy clears a cause and its mask bit when the vector serving that cause has its message acknowledged, so no software access is needed. The auto-mask policy enables a cause's mask bit at the moment the cause is set.

Cause bit order: bit 0 transmit queue 0, bit 1 transmit queue 1, bit 2 receive queue 0, bit 3 receive queue 1, bit 4 other events.

Top module: `irq_vec_mapper`

## Requirements
- R1: After synchronous reset the cause, mask, auto-clear, auto-mask and allocation registers read 0, and no vector request is asserted.
- R2: A 1 on any bit of `ev_i` sets that cause bit at the next clock edge. Address 0 reads the cause register. A write to address 0 clears every cause bit written as 1 and leaves the others alone.
- R3: A write to address 1 sets every cause bit written as 1. Bits written as 0 have no effect. Address 1 reads as 0.
- R4: A write to address 2 sets every mask bit written as 1. A write to address 3 clears every mask bit written as 1. Bits written as 0 have no effect at either address. Address 2 reads the mask.
- R5: Address 6 holds the allocation table. Cause c uses bits [4c+3:4c] of that register: bit 4c+3 is the valid flag and bits [4c+2:4c] are the vector index. When a cause bit is set and its mask bit is 1, `msg_req` of the selected vector rises on the clock edge after the edge that made the cause pending.
- R6: A cause whose mask bit is 0 raises no request. Setting its mask bit later raises the request.
- R7: A cause whose allocation entry is invalid, or whose index is above 4, never raises any request.
- R8: A request stays high until `msg_ack` of that vector is sampled high. It is low in the cycle after the acknowledge.
- R9: A cause that arrives while its vector's request is pending is merged into that request. With auto-clear enabled, one acknowledge clears both causes and no second message follows.
- R10: Address 4 is the auto-clear register. On an acknowledge, every cause routed to that vector with its auto-clear bit set has both its cause bit and its mask bit cleared. All other mask bits are kept.
- R11: Address 5 is the auto-mask register. When a cause bit is set by an event or by a cause-set write and its auto-mask bit is 1, its mask bit becomes 1 on the same edge.
- R12: Without auto-clear, a cause that is still pending and unmasked after an acknowledge raises its vector's request again one cycle later. This repeats until software clears the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | NCAUSE | Hardware cause events, one bit per cause |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational from address) |
| msg_req | output | NVEC | Per-vector message request |
| msg_ack | input | NVEC | Per-vector acknowledge from the message generator |

## Verification
Single causes are driven on vectors that are masked, unmasked, invalidly mapped and mapped out of range. This separates routing faults from masking faults. Acknowledges are given with auto-clear off, which must produce a repeated message, and with auto-clear on, which must not. A second cause is merged into a pending request to show that one acknowledge covers both causes. A cause-set write with auto-mask enabled shows that the mask is enabled by hardware and not by the write path.

// File: rtl/icm_pkg.sv
// Package: shared sizes and register address map for the interrupt mapper.
// Assumes the allocation table (NCAUSE entries of ENT_W bits) fits in DW.
package icm_pkg;
    localparam int NCAUSE_D = 5;
    localparam int NVEC_D   = 5;
    localparam int DW_D     = 32;
    localparam int VIDX_W   = 3;
    localparam int ENT_W    = VIDX_W + 1;
    localparam int REG_AW   = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CAUSE = 3'd0,
        RA_CSET  = 3'd1,
        RA_MSET  = 3'd2,
        RA_MCLR  = 3'd3,
        RA_ACLR  = 3'd4,
        RA_AMSK  = 3'd5,
        RA_ALLOC = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/icm_regfile.sv
// Module: register state of the mapper (cause, mask, policies, allocation).
// Set sources win over clear sources on the same edge, so no event is lost.
// Assumes one register access per cycle and DW > NCAUSE*ENT_W.
module icm_regfile
    import icm_pkg::*;
#(
    parameter int NCAUSE = NCAUSE_D,
    parameter int DW     = DW_D
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCAUSE-1:0]        ev,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        addr,
    input  logic [DW-1:0]            wdata,
    input  logic [NCAUSE-1:0]        cause_done,
    output logic [NCAUSE-1:0]        cause_q,
    output logic [NCAUSE-1:0]        mask_q,
    output logic [NCAUSE-1:0]        aclr_q,
    output logic [NCAUSE*ENT_W-1:0]  alloc_q,
    output logic [DW-1:0]            rdata
);
    localparam int ALLOC_W = NCAUSE * ENT_W;

    logic [NCAUSE-1:0] amsk_q;
    logic [NCAUSE-1:0] wbits;
    logic [NCAUSE-1:0] set_c, clr_c, set_m, clr_m;
    logic              unused_hi;

    assign wbits     = wdata[NCAUSE-1:0];
    assign unused_hi = ^wdata[DW-1:ALLOC_W];

    // Collect set and clear sources for cause and mask bits.
    always_comb begin
        set_c = ev | ((wr_en && addr == RA_CSET) ? wbits : '0);
        clr_c = cause_done | ((wr_en && addr == RA_CAUSE) ? wbits : '0);
        set_m = (set_c & amsk_q) | ((wr_en && addr == RA_MSET) ? wbits : '0);
        clr_m = cause_done | ((wr_en && addr == RA_MCLR) ? wbits : '0);
    end

    // Cause and mask state update, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            cause_q <= (cause_q & ~clr_c) | set_c;
            mask_q  <= (mask_q & ~clr_m) | set_m;
        end
    end

    // Plain read/write policy and allocation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aclr_q  <= '0;
            amsk_q  <= '0;
            alloc_q <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_ACLR:  aclr_q  <= wbits;
                RA_AMSK:  amsk_q  <= wbits;
                RA_ALLOC: alloc_q <= wdata[ALLOC_W-1:0];
                default:  ;
            endcase
        end
    end

    // Read mux; write-only action registers read as zero.
    always_comb begin
        case (addr)
            RA_CAUSE: rdata = DW'(cause_q);
            RA_MSET:  rdata = DW'(mask_q);
            RA_ACLR:  rdata = DW'(aclr_q);
            RA_AMSK:  rdata = DW'(amsk_q);
            RA_ALLOC: rdata = DW'(alloc_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/icm_route.sv
// Module: routes pending unmasked causes to vectors via the allocation table
// and reports which causes are auto-cleared by an acknowledged vector.
// Assumes entry layout {valid, index}; indices >= NVEC are dropped.
module icm_route
    import icm_pkg::*;
#(
    parameter int NCAUSE = NCAUSE_D,
    parameter int NVEC   = NVEC_D
) (
    input  logic [NCAUSE-1:0]       cause_q,
    input  logic [NCAUSE-1:0]       mask_q,
    input  logic [NCAUSE-1:0]       aclr_q,
    input  logic [NCAUSE*ENT_W-1:0] alloc_q,
    input  logic [NVEC-1:0]         fire,
    output logic [NVEC-1:0]         vec_pend,
    output logic [NCAUSE-1:0]       cause_done
);
    localparam logic [VIDX_W:0] NVEC_LIM = (VIDX_W+1)'(NVEC);

    logic [NVEC-1:0] hit [NCAUSE];

    // One decoder per cause: a one-hot vector select or all zero.
    for (genvar c = 0; c < NCAUSE; c++) begin : g_cause
        logic [ENT_W-1:0] ent;
        logic             ok;
        assign ent = alloc_q[c*ENT_W +: ENT_W];
        assign ok  = ent[ENT_W-1] && ({1'b0, ent[VIDX_W-1:0]} < NVEC_LIM);
        for (genvar v = 0; v < NVEC; v++) begin : g_vsel
            assign hit[c][v] = ok && (ent[VIDX_W-1:0] == VIDX_W'(v));
        end
        // Cause finished when its vector fires and auto-clear is on.
        assign cause_done[c] = aclr_q[c] && |(hit[c] & fire);
    end

    // Vector is pending when any routed cause is set and unmasked.
    always_comb begin
        vec_pend = '0;
        for (int c = 0; c < NCAUSE; c++) begin
            if (cause_q[c] && mask_q[c]) vec_pend = vec_pend | hit[c];
        end
    end
endmodule

// File: rtl/icm_vreq.sv
// Module: per-vector request registers with a req/ack handshake.
// A raised request holds until acknowledged, then drops for one cycle.
module icm_vreq #(
    parameter int NVEC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] vec_pend,
    input  logic [NVEC-1:0] ack,
    output logic [NVEC-1:0] req_q,
    output logic [NVEC-1:0] fire
);
    assign fire = req_q & ack;

    // Hold while waiting for ack, otherwise follow pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~ack) | (~req_q & vec_pend);
    end
endmodule

// File: rtl/irq_vec_mapper.sv
// Module: top of the interrupt cause and vector mapper.
// Joins register state, routing and per-vector requests. The acknowledge
// feeds back combinationally into the auto-clear of cause and mask bits.
module irq_vec_mapper
    import icm_pkg::*;
#(
    parameter int NCAUSE = NCAUSE_D,
    parameter int NVEC   = NVEC_D,
    parameter int DW     = DW_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] ev_i,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NVEC-1:0]   msg_req,
    input  logic [NVEC-1:0]   msg_ack
);
    logic [NCAUSE-1:0]       cause_q, mask_q, aclr_q, cause_done;
    logic [NCAUSE*ENT_W-1:0] alloc_q;
    logic [NVEC-1:0]         vec_pend, fire;

    icm_regfile #(.NCAUSE(NCAUSE), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .ev(ev_i), .wr_en(reg_wr),
        .addr(reg_addr), .wdata(reg_wdata), .cause_done(cause_done),
        .cause_q(cause_q), .mask_q(mask_q), .aclr_q(aclr_q),
        .alloc_q(alloc_q), .rdata(reg_rdata)
    );

    icm_route #(.NCAUSE(NCAUSE), .NVEC(NVEC)) u_route (
        .cause_q(cause_q), .mask_q(mask_q), .aclr_q(aclr_q),
        .alloc_q(alloc_q), .fire(fire), .vec_pend(vec_pend),
        .cause_done(cause_done)
    );

    icm_vreq #(.NVEC(NVEC)) u_vreq (
        .clk(clk), .rst_n(rst_n), .vec_pend(vec_pend), .ack(msg_ack),
        .req_q(msg_req), .fire(fire)
    );
endmodule

// File: rtl/irq_vec_mapper_chk.sv
// Module: protocol and register checker bound to the mapper top.
// Assumes synchronous active-low reset; all properties disabled in reset.
module irq_vec_mapper_chk
    import icm_pkg::*;
#(
    parameter int NCAUSE = NCAUSE_D,
    parameter int NVEC   = NVEC_D,
    parameter int DW     = DW_D
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCAUSE-1:0] ev_i,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [NVEC-1:0]   msg_req,
    input logic [NVEC-1:0]   msg_ack,
    input logic [NCAUSE-1:0] cause_q,
    input logic [NCAUSE-1:0] mask_q
);
    logic [NCAUSE-1:0] wb;
    logic              unused_chk;
    assign wb         = reg_wdata[NCAUSE-1:0];
    assign unused_chk = ^reg_wdata[DW-1:NCAUSE];

    for (genvar v = 0; v < NVEC; v++) begin : g_v
        AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_req[v] && !msg_ack[v]) |=> msg_req[v]); // R8
        AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_req[v] && msg_ack[v]) |=> !msg_req[v]); // R8
        AST_REQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(msg_req[v]) |-> $past(|(cause_q & mask_q))); // R6
    end

    AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((cause_q & $past(ev_i)) == $past(ev_i))); // R2
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CSET) |=> ((cause_q & $past(wb)) == $past(wb))); // R3
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_MCLR && ev_i == '0) |=> ((mask_q & $past(wb)) == '0)); // R4
endmodule

bind irq_vec_mapper irq_vec_mapper_chk #(.NCAUSE(NCAUSE), .NVEC(NVEC), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .msg_req(msg_req),
    .msg_ack(msg_ack), .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/sim_irq_vec_mapper.sv
module sim_irq_vec_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 5;
    localparam int NV = 5;
    localparam int WATCHDOG = 20000;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NC-1:0] ev_i = '0;
    logic          reg_wr = 0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NV-1:0] msg_req;
    logic [NV-1:0] msg_ack = '0;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    logic [NV-1:0] prev_req = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_mapper u0 (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_req(msg_req), .msg_ack(msg_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_ev(input logic [NC-1:0] b);
        @(negedge clk); ev_i = b;
        @(negedge clk); ev_i = '0;
    endtask

    task automatic ack(input int v);
        @(negedge clk); msg_ack[v] = 1'b1;
        @(negedge clk); msg_ack = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every rising request must match the next expected vector.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int v = 0; v < NV; v++) begin
                if (msg_req[v] && !prev_req[v]) begin
                    if (exp_q.size() == 0) chk("R5 unexpected message", v, 32'hFFFF_FFFF);
                    else chk("R5 message vector", v, exp_q.pop_front());
                end
            end
        end
        prev_req = msg_req;
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++; fails++;
        $display("FAIL R8 watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 no request", msg_req, 0);
        rd_chk("R1 cause", 3'd0, 0);
        rd_chk("R1 mask", 3'd2, 0);
        rd_chk("R1 autoclear", 3'd4, 0);
        rd_chk("R1 automask", 3'd5, 0);
        rd_chk("R1 alloc", 3'd6, 0);

        // Allocation: c0->v0, c1->v1, c2 invalid, c3 index 5, c4->v4
        wr(3'd6, 32'h000CD298);
        rd_chk("R5 alloc readback", 3'd6, 32'h000CD298);
        wr(3'd2, 32'h1F);
        rd_chk("R4 mask set", 3'd2, 32'h1F);
        wr(3'd3, 32'h02);
        rd_chk("R4 mask clear", 3'd2, 32'h1D);
        wr(3'd2, 32'h0);
        rd_chk("R4 zero set no effect", 3'd2, 32'h1D);
        wr(3'd3, 32'h0);
        rd_chk("R4 zero clear no effect", 3'd2, 32'h1D);
        wr(3'd1, 32'h0);
        rd_chk("R3 zero cause-set no effect", 3'd0, 0);
        rd_chk("R3 cause-set reads zero", 3'd1, 0);

        // Routing and hold, no auto-clear
        exp_q.push_back(0);
        pulse_ev(5'h01);
        idle(1);
        chk("R5 v0 request", msg_req, 5'h01);
        rd_chk("R2 event captured", 3'd0, 32'h01);
        idle(3);
        chk("R8 held without ack", msg_req, 5'h01);
        exp_q.push_back(0);
        ack(0);
        chk("R8 drop after ack", msg_req, 5'h00);
        idle(1);
        chk("R12 re-raise while pending", msg_req, 5'h01);
        wr(3'd0, 32'h01);
        rd_chk("R2 write-1-clear cause", 3'd0, 0);
        chk("R8 held after cause cleared", msg_req, 5'h01);
        ack(0);
        idle(3);
        chk("R12 quiet after software clear", msg_req, 0);

        // Masked cause
        pulse_ev(5'h02);
        idle(4);
        chk("R6 masked no request", msg_req, 0);
        rd_chk("R6 masked cause pending", 3'd0, 32'h02);
        exp_q.push_back(1);
        wr(3'd2, 32'h02);
        idle(1);
        chk("R6 unmask raises v1", msg_req, 5'h02);
        wr(3'd0, 32'h02);
        ack(1);
        idle(2);
        chk("R8 v1 idle", msg_req, 0);

        // Invalid and out-of-range entries
        pulse_ev(5'h0C);
        idle(5);
        chk("R7 no routing", msg_req, 0);
        rd_chk("R7 causes held", 3'd0, 32'h0C);
        wr(3'd0, 32'h0C);

        // Auto-clear and merge on v4: c0->v4, c4->v4
        wr(3'd6, 32'h000CD29C);
        wr(3'd4, 32'h11);
        rd_chk("R10 autoclear readback", 3'd4, 32'h11);
        exp_q.push_back(4);
        pulse_ev(5'h10);
        idle(1);
        chk("R5 v4 request", msg_req, 5'h10);
        pulse_ev(5'h01);
        rd_chk("R9 merged causes", 3'd0, 32'h11);
        ack(4);
        rd_chk("R10 causes auto-cleared", 3'd0, 0);
        rd_chk("R10 mask bits auto-cleared", 3'd2, 32'h0E);
        idle(4);
        chk("R9 no second message", msg_req, 0);

        // Auto-mask
        wr(3'd5, 32'h01);
        exp_q.push_back(4);
        wr(3'd1, 32'h01);
        rd_chk("R11 mask set by hardware", 3'd2, 32'h0F);
        idle(1);
        chk("R11 request after automask", msg_req, 5'h10);
        ack(4);
        rd_chk("R10 mask cleared again", 3'd2, 32'h0E);
        rd_chk("R10 cause cleared again", 3'd0, 0);
        idle(3);

        chk("R9 all expected messages seen", exp_q.size(), 0);
        finish_run();
    end
endmodule